// File: doc/BRIEF.md
# Loopback Integer Delay Estimator

This block measures the round-trip delay, in whole samples, between a synchronizing burst that a transmitter sends and the same burst coming back through a loopback path such as a cable or a device under test. Software pulses `start`. The block then raises `tx_go` for one cycle to launch the burst, restarts its sample index and flushes its pipeline. Each complex receive sample is reduced to a magnitude estimate, |I|+|Q|. The block differences consecutive magnitudes and slides the resulting stream past a stored reference. That reference is the magnitude-difference stream of a Zadoff-Chu sequence, and it is computed when the design is elaborated.

The first time the sliding dot product exceeds a run-time threshold, the block stores the delay and emits a one-cycle `trig`. It also raises `aligned`, which later stages use as their enable. The threshold is an input because the level of the received signal depends on the cable in use. If no crossing occurs within a programmable number of cycles, the measurement ends with `timeout` set. The stored delay stays unchanged until a later measurement succeeds.

Top module: `loop_delay_est`

## Requirements
- R1: After reset, `busy`, `trig`, `aligned`, `timeout` and `tx_go` are 0 and `delay` is 0.
- R2: A cycle with `start` high makes `tx_go` high for exactly the next cycle. From the next cycle, `busy` is 1 and `aligned` and `timeout` are 0. This also holds when `busy` was already 1, and in that case any measurement in progress is abandoned.
- R3: A receive sample is accepted only in a cycle with `rx_valid`=1, `busy`=1 and `start`=0. Index j=0 is the first sample accepted after `start`. Samples offered while idle have no effect on any output.
- R4: For accepted samples, m[j]=|I|+|Q| and d[j]=m[j]−m[j−1], with m[−1]=0.
- R5: The reference taps are r[k]=a(k+1)−a(k) for k=0..L−1, with L=63. Here a(n)=round(1000·(|cos φ|+|sin φ|)) and φ=π·n·(n+1)/63, where n is taken modulo 63.
- R6: For each j≥L, c[j]=Σ r[k]·d[j−L+1+k] over k=0..L−1. No correlation is formed for j<L.
- R7: Detection occurs at the first j where c[j] > `threshold`, both read as signed two's complement. Strict comparison is used. `delay` then becomes j−L.
- R8: On detection, `trig` is high for exactly one cycle, 3 clock edges after the edge that accepted sample j. In the same cycle `aligned` becomes 1 and `busy` becomes 0.
- R9: Only the first crossing after a `start` is used. `delay` changes only on detection and keeps its value through later samples and timeouts.
- R10: Without detection, `busy` stays 1 for exactly `timeout_limit` cycles (limit ≥ 1). After that `busy` is 0 and `timeout` is 1.
- R11: Cycles with `rx_valid`=0 are skipped, whatever the data inputs carry. The delay counts accepted samples only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle measurement launch |
| threshold | input | 36 | Signed detection threshold |
| timeout_limit | input | 20 | Cycles allowed for a measurement |
| rx_valid | input | 1 | Receive sample strobe |
| rx_i | input | 16 | Receive in-phase sample, signed |
| rx_q | input | 16 | Receive quadrature sample, signed |
| tx_go | output | 1 | Burst launch pulse |
| busy | output | 1 | Measurement in progress |
| trig | output | 1 | One-cycle detection pulse |
| aligned | output | 1 | Detection done; enables later stages |
| timeout | output | 1 | Measurement ended without detection |
| delay | output | 16 | Integer loopback delay in samples |

## Verification
Almost any fault inside the block shows up as a wrong `delay`, or as a `trig` in the wrong cycle, because every stage sits on the path from the accepted sample to that register. A wrong tap, a bad difference register or a stale window moves the first crossing, and the bench catches this within three edges of the completing sample. A broken index tag or a missed flush on `start` shifts `delay` by a fixed amount. Faults in the timeout counter or in the busy logic change how many cycles `busy` stays high, and that count is checked to the exact cycle.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  localparam real PI_R = 3.14159265358979;

  // |cos|+|sin| magnitude of the unit-root ZC point n, scaled and rounded
  function automatic int zc_absum(int n, int amp, int root, int len);
    real ph, c, s;
    int  nm;
    nm = n % len;
    ph = PI_R * real'(root) * real'(nm) * real'(nm + 1) / real'(len);
    c  = $cos(ph);
    s  = $sin(ph);
    if (c < 0.0) c = -c;
    if (s < 0.0) s = -s;
    return $rtoi(real'(amp) * (c + s) + 0.5);
  endfunction

  function automatic int ref_tap(int k, int amp, int root, int len);
    return zc_absum(k + 1, amp, root, len) - zc_absum(k, amp, root, len);
  endfunction
endpackage

// File: rtl/ldm_magdiff.sv
module ldm_magdiff #(
  parameter int IN_W  = 16,
  parameter int CNT_W = 16,
  localparam int MAG_W = IN_W + 1,
  localparam int D_W   = MAG_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    accept,
  input  logic signed [IN_W-1:0]  in_i,
  input  logic signed [IN_W-1:0]  in_q,
  output logic signed [D_W-1:0]   d_out,
  output logic                    d_valid,
  output logic [CNT_W-1:0]        d_tag
);
  logic signed [MAG_W-1:0] ext_i, ext_q, abs_i, abs_q;
  logic [MAG_W-1:0] mag_new, mag_q, mag_prev;
  logic [CNT_W-1:0] idx;

  always_comb begin
    ext_i   = MAG_W'(in_i);
    ext_q   = MAG_W'(in_q);
    abs_i   = ext_i[MAG_W-1] ? -ext_i : ext_i;
    abs_q   = ext_q[MAG_W-1] ? -ext_q : ext_q;
    mag_new = MAG_W'(unsigned'(abs_i)) + MAG_W'(unsigned'(abs_q));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      d_valid  <= 1'b0;
      idx      <= '0;
      mag_q    <= '0;
      mag_prev <= '0;
      d_tag    <= '0;
    end else begin
      d_valid <= accept;
      if (accept) begin
        mag_q <= mag_new;
        d_tag <= idx;
        idx   <= idx + 1'b1;
      end
      if (d_valid) mag_prev <= mag_q;
    end
  end

  assign d_out = signed'({1'b0, mag_q}) - signed'({1'b0, mag_prev});

  a_r11_valid_from_accept: assert property (@(posedge clk) disable iff (rst)
    d_valid |-> $past(accept));
  a_r3_tag_steps: assert property (@(posedge clk) disable iff (rst)
    (d_valid && $past(d_valid) && !$past(clr)) |-> (d_tag == $past(d_tag) + 1'b1));
endmodule

// File: rtl/ldm_corr.sv
module ldm_corr #(
  parameter int D_W     = 18,
  parameter int TAPS    = 63,
  parameter int ZC_LEN  = 63,
  parameter int ZC_ROOT = 1,
  parameter int REF_AMP = 1000,
  parameter int REF_W   = 12,
  parameter int CNT_W   = 16,
  localparam int ACC_W  = D_W + REF_W + $clog2(TAPS),
  localparam int FILL_W = $clog2(TAPS + 2)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic signed [D_W-1:0]   din,
  input  logic                    din_valid,
  input  logic [CNT_W-1:0]        din_tag,
  output logic signed [ACC_W-1:0] corr,
  output logic                    corr_valid,
  output logic [CNT_W-1:0]        corr_tag
);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(TAPS + 1);

  logic signed [D_W-1:0]   line [TAPS];
  logic signed [ACC_W-1:0] prod [TAPS];
  logic signed [ACC_W-1:0] sum;
  logic [FILL_W-1:0]       fill;
  logic                    line_v;
  logic [CNT_W-1:0]        line_tag;

  always_ff @(posedge clk) begin
    if (din_valid) begin
      for (int k = 0; k < TAPS - 1; k++) line[k] <= line[k+1];
      line[TAPS-1] <= din;
    end
  end

  genvar g;
  generate
    for (g = 0; g < TAPS; g++) begin : g_tap
      localparam logic signed [REF_W-1:0] TAP =
        REF_W'(ldm_pkg::ref_tap(g, REF_AMP, ZC_ROOT, ZC_LEN));
      assign prod[g] = ACC_W'(line[g]) * ACC_W'(TAP);
    end
  endgenerate

  always_comb begin
    sum = '0;
    for (int k = 0; k < TAPS; k++) sum = sum + prod[k];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fill       <= '0;
      line_v     <= 1'b0;
      line_tag   <= '0;
      corr       <= '0;
      corr_valid <= 1'b0;
      corr_tag   <= '0;
    end else begin
      line_v <= din_valid;
      if (din_valid) begin
        line_tag <= din_tag;
        if (fill != FILL_MAX) fill <= fill + 1'b1;
      end
      corr_valid <= line_v && (fill == FILL_MAX);
      if (line_v) begin
        corr     <= sum;
        corr_tag <= line_tag;
      end
    end
  end

  a_r6_full_window_only: assert property (@(posedge clk) disable iff (rst)
    corr_valid |-> $past(line_v));
  a_r6_no_early_result: assert property (@(posedge clk) disable iff (rst)
    corr_valid |-> (corr_tag >= CNT_W'(TAPS)));
endmodule

// File: rtl/ldm_ctrl.sv
module ldm_ctrl #(
  parameter int ACC_W = 36,
  parameter int CNT_W = 16,
  parameter int TO_W  = 20,
  parameter int TAPS  = 63
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic signed [ACC_W-1:0] threshold,
  input  logic [TO_W-1:0]         timeout_limit,
  input  logic signed [ACC_W-1:0] corr,
  input  logic                    corr_valid,
  input  logic [CNT_W-1:0]        corr_tag,
  output logic                    tx_go,
  output logic                    busy,
  output logic                    trig,
  output logic                    aligned,
  output logic                    timeout,
  output logic [CNT_W-1:0]        delay
);
  logic [TO_W-1:0] cyc_q;
  logic            hit;

  assign hit = corr_valid && (corr > threshold);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_go   <= 1'b0;
      busy    <= 1'b0;
      trig    <= 1'b0;
      aligned <= 1'b0;
      timeout <= 1'b0;
      delay   <= '0;
      cyc_q   <= '0;
    end else begin
      tx_go <= start;
      trig  <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        aligned <= 1'b0;
        timeout <= 1'b0;
        cyc_q   <= '0;
      end else if (busy) begin
        if (hit) begin
          trig    <= 1'b1;
          aligned <= 1'b1;
          busy    <= 1'b0;
          delay   <= corr_tag - CNT_W'(TAPS);
        end else if (cyc_q == timeout_limit - TO_W'(1)) begin
          busy    <= 1'b0;
          timeout <= 1'b1;
        end else begin
          cyc_q <= cyc_q + 1'b1;
        end
      end
    end
  end

  a_r2_go_follows_start: assert property (@(posedge clk) disable iff (rst)
    tx_go |-> $past(start));
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    ($past(start) && !$past(rst)) |-> (busy && !aligned && !timeout));
  a_r8_trig_single: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);
  a_r8_trig_ends_busy: assert property (@(posedge clk) disable iff (rst)
    trig |-> ($past(busy) && !busy && aligned));
  a_r8_aligned_by_trig: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> trig);
  a_r9_delay_hold: assert property (@(posedge clk) disable iff (rst)
    !trig |-> $stable(delay));
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && timeout));
endmodule

// File: rtl/loop_delay_est.sv
module loop_delay_est #(
  parameter int IN_W    = 16,
  parameter int TAPS    = 63,
  parameter int ZC_LEN  = 63,
  parameter int ZC_ROOT = 1,
  parameter int REF_AMP = 1000,
  parameter int REF_W   = 12,
  parameter int CNT_W   = 16,
  parameter int TO_W    = 20,
  localparam int D_W    = IN_W + 2,
  localparam int ACC_W  = D_W + REF_W + $clog2(TAPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic signed [ACC_W-1:0] threshold,
  input  logic [TO_W-1:0]         timeout_limit,
  input  logic                    rx_valid,
  input  logic signed [IN_W-1:0]  rx_i,
  input  logic signed [IN_W-1:0]  rx_q,
  output logic                    tx_go,
  output logic                    busy,
  output logic                    trig,
  output logic                    aligned,
  output logic                    timeout,
  output logic [CNT_W-1:0]        delay
);
  logic                    accept;
  logic signed [D_W-1:0]   d_val;
  logic                    d_valid;
  logic [CNT_W-1:0]        d_tag;
  logic signed [ACC_W-1:0] corr;
  logic                    corr_valid;
  logic [CNT_W-1:0]        corr_tag;

  assign accept = rx_valid && busy && !start;

  ldm_magdiff #(.IN_W(IN_W), .CNT_W(CNT_W)) u_md (
    .clk(clk), .rst(rst), .clr(start), .accept(accept),
    .in_i(rx_i), .in_q(rx_q),
    .d_out(d_val), .d_valid(d_valid), .d_tag(d_tag)
  );

  ldm_corr #(
    .D_W(D_W), .TAPS(TAPS), .ZC_LEN(ZC_LEN), .ZC_ROOT(ZC_ROOT),
    .REF_AMP(REF_AMP), .REF_W(REF_W), .CNT_W(CNT_W)
  ) u_corr (
    .clk(clk), .rst(rst), .clr(start),
    .din(d_val), .din_valid(d_valid), .din_tag(d_tag),
    .corr(corr), .corr_valid(corr_valid), .corr_tag(corr_tag)
  );

  ldm_ctrl #(.ACC_W(ACC_W), .CNT_W(CNT_W), .TO_W(TO_W), .TAPS(TAPS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .threshold(threshold), .timeout_limit(timeout_limit),
    .corr(corr), .corr_valid(corr_valid), .corr_tag(corr_tag),
    .tx_go(tx_go), .busy(busy), .trig(trig), .aligned(aligned),
    .timeout(timeout), .delay(delay)
  );

  a_r3_idle_ignored: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(start)) |-> !trig);
endmodule

// File: tb/sim_loop_delay_est.sv
`timescale 1ns/1ps
module sim_loop_delay_est;
  localparam int L   = 63;
  localparam int NS  = 256;
  localparam int ACW = 36;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, start, rx_valid;
  logic signed [ACW-1:0] threshold;
  logic [19:0] timeout_limit;
  logic signed [15:0] rx_i, rx_q;
  logic tx_go, busy, trig, aligned, timeout;
  logic [15:0] delay;

  loop_delay_est u0 (
    .clk(clk), .rst(rst), .start(start), .threshold(threshold),
    .timeout_limit(timeout_limit), .rx_valid(rx_valid), .rx_i(rx_i), .rx_q(rx_q),
    .tx_go(tx_go), .busy(busy), .trig(trig), .aligned(aligned),
    .timeout(timeout), .delay(delay)
  );

  int checks = 0, errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int trig_cnt = 0;
  longint trig_cyc = -1;
  always @(negedge clk) if (trig) begin trig_cnt++; trig_cyc = cyc; end

  int si[NS], sq[NS], reft[L];
  longint acc_cyc[NS];

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int amag(int n);
    real ph = PI * real'(n % 63) * real'((n % 63) + 1) / 63.0;
    real c = $cos(ph), s = $sin(ph);
    if (c < 0.0) c = -c;
    if (s < 0.0) s = -s;
    return $rtoi(1000.0 * (c + s) + 0.5);
  endfunction

  task automatic place(int at);
    for (int n = 0; n <= L; n++) begin
      real ph = -PI * real'(n % 63) * real'((n % 63) + 1) / 63.0;
      if (at + n < NS) begin
        si[at+n] = rnd(8000.0 * $cos(ph));
        sq[at+n] = rnd(8000.0 * $sin(ph));
      end
    end
  endtask

  task automatic build(int d1, int d2);
    for (int n = 0; n < NS; n++) begin si[n] = 0; sq[n] = 0; end
    place(d1);
    if (d2 >= 0) place(d2);
  endtask

  function automatic longint corr_at(int j);
    longint acc = 0;
    for (int k = 0; k < L; k++) begin
      int p = j - L + 1 + k;
      int mc = (si[p] < 0 ? -si[p] : si[p]) + (sq[p] < 0 ? -sq[p] : sq[p]);
      int mp = (p == 0) ? 0 :
               (si[p-1] < 0 ? -si[p-1] : si[p-1]) + (sq[p-1] < 0 ? -sq[p-1] : sq[p-1]);
      acc += longint'(reft[k]) * longint'(mc - mp);
    end
    return acc;
  endfunction

  function automatic int first_hit(longint thr, int upto);
    for (int j = L; j < upto; j++) if (corr_at(j) > thr) return j;
    return -1;
  endfunction

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(tx_go == 1'b1, "R2 tx_go pulse", tx_go, 1);
    chk(busy == 1'b1 && aligned == 1'b0 && timeout == 1'b0, "R2 busy after start", busy, 1);
    @(negedge clk);
    chk(tx_go == 1'b0, "R2 tx_go one cycle", tx_go, 0);
  endtask

  task automatic drive(int n, bit gap);
    for (int j = 0; j < n; j++) begin
      if (gap) begin
        @(negedge clk); rx_valid = 1'b0; rx_i = 16'sh7fff; rx_q = -16'sh7fff;
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_i = 16'(si[j]); rx_q = 16'(sq[j]);
      acc_cyc[j] = cyc + 1;
    end
    @(negedge clk); rx_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_detect(string nm, int d1, int d2, bit gap, int num, int den);
    longint thr;
    int j;
    build(d1, d2);
    thr = corr_at(d1 + L) * num / den;
    threshold = ACW'(thr);
    j = first_hit(thr, NS);
    trig_cnt = 0;
    do_start();
    drive(NS, gap);
    if (j >= 0) begin
      chk(trig_cnt == 1, {"R8/R9 single trig ", nm}, trig_cnt, 1);
      chk(delay == 16'(j - L), {"R7 delay ", nm}, delay, j - L);
      if (!gap) chk(trig_cyc == acc_cyc[j] + 3, {"R8 trig latency ", nm}, trig_cyc, acc_cyc[j] + 3);
      chk(aligned && !busy && !timeout, {"R8 status ", nm}, {aligned, busy, timeout}, 3'b100);
    end else begin
      chk(trig_cnt == 0 && busy, {"R7 strict no detect ", nm}, trig_cnt, 0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; rx_valid = 1'b0; rx_i = '0; rx_q = '0;
    threshold = '0; timeout_limit = 20'd2000;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, trig, aligned, timeout, tx_go} == 5'b0, "R1 flags", {busy, trig, aligned, timeout, tx_go}, 0);
    chk(delay == 16'd0, "R1 delay", delay, 0);
  endtask

  task automatic t_idle_ignored();
    build(5, -1);
    threshold = ACW'(1);
    trig_cnt = 0;
    drive(NS, 1'b0);
    chk(trig_cnt == 0 && !busy && delay == 16'd0, "R3 idle samples ignored", trig_cnt, 0);
  endtask

  task automatic t_restart();
    build(40, -1);
    threshold = ACW'(corr_at(40 + L) * 3 / 4);
    do_start();
    drive(60, 1'b0);
    chk(trig_cnt == 0 && busy, "R2 partial run busy", busy, 1);
    t_detect("restart", 15, -1, 1'b0, 3, 4);
  endtask

  task automatic t_timeout();
    int busy_n = 0;
    logic [15:0] prev = delay;
    build(20, -1);
    threshold = ACW'(64'sd17179869183);
    timeout_limit = 20'd200;
    trig_cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (busy) busy_n++;
      rx_valid = (k < NS); rx_i = 16'(si[k % NS]); rx_q = 16'(sq[k % NS]);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    chk(busy_n == 200, "R10 busy cycles", busy_n, 200);
    chk(timeout && !busy && !aligned, "R10 timeout flag", timeout, 1);
    chk(trig_cnt == 0 && delay == prev, "R9 delay kept on timeout", delay, prev);
    timeout_limit = 20'd2000;
  endtask

  initial begin
    for (int k = 0; k < L; k++) reft[k] = amag(k + 1) - amag(k);
    t_reset();
    t_idle_ignored();
    t_detect("R4 R5 R6 base", 20, -1, 1'b0, 3, 4);
    t_detect("R11 gaps", 9, -1, 1'b1, 3, 4);
    t_detect("R9 second burst", 10, 130, 1'b0, 3, 4);
    t_detect("R7 thr peak-1", 33, -1, 1'b0, 999, 1000);
    t_detect("R7 thr at peak", 33, -1, 1'b0, 1, 1);
    t_restart();
    t_timeout();
    t_detect("R2 after timeout", 50, -1, 1'b0, 1, 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule